// File: doc/BRIEF.md
# Task Priority Gate with Spurious Vector

This block holds the 8-bit task priority value of an interrupt controller and decides whether the highest pending interrupt may be signalled to the core. The upper four bits of a vector are its priority class, which gives 16 classes. The pending and in-service trackers sit outside the block. Each presents its highest vector together with a valid bit. The gate raises the request line only when the pending class beats both the task priority class and the in-service class.

Software can change the priority value in two ways. One is a full 8-bit register write. The other is a 64-bit control-register view that carries only the class nibble. That view reads back zero-extended. A write to it with any reserved bit set is refused and raises a fault flag for one cycle.

The core acknowledges with a one-cycle strobe. On the next cycle the block returns a registered vector. If the request is still eligible, that vector is the pending one. If the request has become masked in the meantime, the block returns a software-programmable spurious vector and sets a spurious flag. The flag tells the tracker to leave its in-service bitmap alone.

Top module: `task_prio_gate`

## Requirements
- R1: After reset the priority value is 8'h00, the spurious vector is 8'hFF, and intr, ack_valid and cra_fault are all 0.
- R2: A cycle with tpr_wr_en loads tpr_wr_data into the priority value at the next edge. This write wins over an alias write in the same cycle.
- R3: An alias write whose bits [63:4] are zero sets the priority value to {cra_wr_data[3:0], 4'h0}.
- R4: cra_rd_data always equals the priority value's bits [7:4] in bits [3:0], with bits [63:4] zero.
- R5: An alias write with any of bits [63:4] nonzero leaves the priority value unchanged and raises cra_fault for exactly the following cycle.
- R6: intr is 1 exactly when pend_valid is 1 and the pending class (vector bits [7:4]) is strictly greater than the priority class, and is also strictly greater than the in-service class whenever isv_valid is 1. A pending class equal to either one is blocked.
- R7: A priority class of 0 passes every pending class from 1 to 15, and a priority class of 15 blocks every class.
- R8: When inta is high in cycle t and the request is eligible in t, the outputs in cycle t+1 are ack_valid=1, ack_vector=pend_vector and ack_spurious=0. ack_valid is 0 in every cycle that does not follow an inta.
- R9: When inta is high in cycle t and the request is not eligible in t, the outputs in cycle t+1 are ack_valid=1, ack_vector set to the spurious vector and ack_spurious=1.
- R10: A cycle with spv_wr_en loads spv_wr_data into the spurious vector at the next edge. spv_value shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tpr_wr_en | input | 1 | Full priority register write strobe |
| tpr_wr_data | input | 8 | Full priority write data |
| cra_wr_en | input | 1 | Control-register alias write strobe |
| cra_wr_data | input | 64 | Alias write data; only bits [3:0] may be nonzero |
| cra_rd_data | output | 64 | Alias read: priority class, zero-extended |
| spv_wr_en | input | 1 | Spurious vector write strobe |
| spv_wr_data | input | 8 | Spurious vector write data |
| pend_valid | input | 1 | A pending interrupt exists |
| pend_vector | input | 8 | Highest pending vector |
| isv_valid | input | 1 | An interrupt is in service |
| isv_vector | input | 8 | Highest in-service vector |
| inta | input | 1 | Interrupt acknowledge strobe |
| intr | output | 1 | Interrupt request to the core |
| ack_valid | output | 1 | Acknowledge result valid (one cycle after inta) |
| ack_vector | output | 8 | Vector returned to the core |
| ack_spurious | output | 1 | Spurious vector returned; in-service state must not change |
| tpr_value | output | 8 | Current priority value |
| spv_value | output | 8 | Current spurious vector |
| cra_fault | output | 1 | Reserved-bit fault on an alias write |

## Verification
The hardest case to reach is the spurious acknowledge. It needs a request that was legitimately raised and then masked before the core acknowledges it. The stimulus presents an eligible vector and confirms that intr rises. It then raises the priority class through the alias path to the pending class. The acknowledge is pulsed only after that, so the scoreboard expects the programmed spurious vector with the spurious flag set. A second situation is a full write and an alias write arriving in the same cycle. The bench drives both and checks that the full write takes effect.

// File: rtl/tpg_pkg.sv
// Package: shared widths and the acknowledge record for the task priority gate.
// Assumes vectors are VEC_W bits wide, with the class in the upper half.
package tpg_pkg;
    parameter int unsigned VEC_W   = 8;
    parameter int unsigned CLASS_W = VEC_W / 2;

    typedef struct packed {
        logic             valid;
        logic             spurious;
        logic [VEC_W-1:0] vector;
    } tpg_ack_t;

    // Priority class of a vector (upper half of the bits).
    function automatic logic [CLASS_W-1:0] class_of(input logic [VEC_W-1:0] v);
        return v[VEC_W-1 -: CLASS_W];
    endfunction
endpackage

// File: rtl/tpg_prio_reg.sv
// Module: priority and spurious-vector storage, with the control-register alias.
// Assumes that when both write paths fire, the full write has priority.
// Reserved alias bits are checked with a generated reduction.
module tpg_prio_reg
    import tpg_pkg::*;
#(
    parameter int unsigned CR_W      = 64,
    parameter logic [VEC_W-1:0] SPV_RESET = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tpr_wr_en,
    input  logic [VEC_W-1:0] tpr_wr_data,
    input  logic             cra_wr_en,
    input  logic [CR_W-1:0]  cra_wr_data,
    input  logic             spv_wr_en,
    input  logic [VEC_W-1:0] spv_wr_data,
    output logic [VEC_W-1:0] tpr_q,
    output logic [VEC_W-1:0] spv_q,
    output logic             fault_q
);
    localparam int unsigned RSV_W = CR_W - CLASS_W;

    logic [RSV_W-1:0] rsv_bits;
    logic             rsv_bad;

    // Gather the reserved bits of the alias write.
    genvar gi;
    generate
        for (gi = 0; gi < RSV_W; gi++) begin : g_rsv
            assign rsv_bits[gi] = cra_wr_data[CLASS_W + gi];
        end
    endgenerate

    // Any reserved bit set makes the alias write illegal.
    always_comb rsv_bad = |rsv_bits;

    // Priority register with its two write paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= '0;
        end else if (tpr_wr_en) begin
            tpr_q <= tpr_wr_data;
        end else if (cra_wr_en && !rsv_bad) begin
            tpr_q <= {cra_wr_data[CLASS_W-1:0], {(VEC_W-CLASS_W){1'b0}}};
        end
    end

    // One-cycle fault pulse for a refused alias write.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= cra_wr_en && rsv_bad;
    end

    // Spurious vector register.
    always_ff @(posedge clk) begin
        if (!rst_n)         spv_q <= SPV_RESET;
        else if (spv_wr_en) spv_q <= spv_wr_data;
    end
endmodule

// File: rtl/tpg_gate.sv
// Module: eligibility comparator.
// The pending class must be strictly above the task class, and also above
// the in-service class when one is valid. Purely combinational.
module tpg_gate
    import tpg_pkg::*;
(
    input  logic             pend_valid,
    input  logic [VEC_W-1:0] pend_vector,
    input  logic             isv_valid,
    input  logic [VEC_W-1:0] isv_vector,
    input  logic [VEC_W-1:0] tpr_q,
    output logic             eligible
);
    logic [CLASS_W-1:0] pc, tc, ic;
    logic above_task, above_isv;

    // Compare the pending class against both thresholds.
    always_comb begin
        pc         = class_of(pend_vector);
        tc         = class_of(tpr_q);
        ic         = class_of(isv_vector);
        above_task = pc > tc;
        above_isv  = !isv_valid || (pc > ic);
        eligible   = pend_valid && above_task && above_isv;
    end
endmodule

// File: rtl/tpg_ack.sv
// Module: registered acknowledge stage.
// It samples eligibility in the inta cycle and returns the real or the
// spurious vector on the following cycle.
module tpg_ack
    import tpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inta,
    input  logic             eligible,
    input  logic [VEC_W-1:0] pend_vector,
    input  logic [VEC_W-1:0] spv_q,
    output tpg_ack_t         ack_q
);
    // Capture the acknowledge result; valid for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= '0;
        end else begin
            ack_q.valid    <= inta;
            ack_q.spurious <= inta && !eligible;
            ack_q.vector   <= (inta && eligible) ? pend_vector
                            : (inta ? spv_q : '0);
        end
    end
endmodule

// File: rtl/task_prio_gate.sv
// Module: task priority gate top.
// It connects the storage, the comparator and the acknowledge stage, and it
// produces the zero-extended alias read. It assumes the external trackers
// present their highest pending and in-service vectors.
module task_prio_gate
    import tpg_pkg::*;
#(
    parameter int unsigned CR_W      = 64,
    parameter logic [7:0]  SPV_RESET = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tpr_wr_en,
    input  logic [7:0]       tpr_wr_data,
    input  logic             cra_wr_en,
    input  logic [CR_W-1:0]  cra_wr_data,
    output logic [CR_W-1:0]  cra_rd_data,
    input  logic             spv_wr_en,
    input  logic [7:0]       spv_wr_data,
    input  logic             pend_valid,
    input  logic [7:0]       pend_vector,
    input  logic             isv_valid,
    input  logic [7:0]       isv_vector,
    input  logic             inta,
    output logic             intr,
    output logic             ack_valid,
    output logic [7:0]       ack_vector,
    output logic             ack_spurious,
    output logic [7:0]       tpr_value,
    output logic [7:0]       spv_value,
    output logic             cra_fault
);
    logic [VEC_W-1:0] tpr_q, spv_q;
    logic             fault_q, eligible;
    tpg_ack_t         ack_q;

    tpg_prio_reg #(.CR_W(CR_W), .SPV_RESET(SPV_RESET)) u_reg (
        .clk(clk), .rst_n(rst_n),
        .tpr_wr_en(tpr_wr_en), .tpr_wr_data(tpr_wr_data),
        .cra_wr_en(cra_wr_en), .cra_wr_data(cra_wr_data),
        .spv_wr_en(spv_wr_en), .spv_wr_data(spv_wr_data),
        .tpr_q(tpr_q), .spv_q(spv_q), .fault_q(fault_q)
    );

    tpg_gate u_gate (
        .pend_valid(pend_valid), .pend_vector(pend_vector),
        .isv_valid(isv_valid), .isv_vector(isv_vector),
        .tpr_q(tpr_q), .eligible(eligible)
    );

    tpg_ack u_ack (
        .clk(clk), .rst_n(rst_n), .inta(inta), .eligible(eligible),
        .pend_vector(pend_vector), .spv_q(spv_q), .ack_q(ack_q)
    );

    // Drive the outputs; the alias read is the class, zero-extended.
    always_comb begin
        cra_rd_data  = {{(CR_W-CLASS_W){1'b0}}, class_of(tpr_q)};
        intr         = eligible;
        ack_valid    = ack_q.valid;
        ack_vector   = ack_q.vector;
        ack_spurious = ack_q.spurious;
        tpr_value    = tpr_q;
        spv_value    = spv_q;
        cra_fault    = fault_q;
    end
endmodule

// File: rtl/task_prio_gate_chk.sv
// Checker: port-level properties of the task priority gate, bound to the top.
module task_prio_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tpr_wr_en,
    input logic        cra_wr_en,
    input logic [63:0] cra_wr_data,
    input logic [63:0] cra_rd_data,
    input logic        pend_valid,
    input logic [7:0]  pend_vector,
    input logic        isv_valid,
    input logic [7:0]  isv_vector,
    input logic        inta,
    input logic        intr,
    input logic        ack_valid,
    input logic        ack_vector_unused_free,
    input logic        ack_spurious,
    input logic [7:0]  tpr_value,
    input logic        cra_fault
);
    AST_READ_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        cra_rd_data[63:4] == 60'h0 && cra_rd_data[3:0] == tpr_value[7:4]); // R4
    AST_BAD_ALIAS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cra_wr_en && !tpr_wr_en && cra_wr_data[63:4] != 60'h0) |=> (cra_fault && $stable(tpr_value))); // R5
    AST_GOOD_ALIAS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cra_wr_en && !tpr_wr_en && cra_wr_data[63:4] == 60'h0) |=> (tpr_value == {$past(cra_wr_data[3:0]), 4'h0} && !cra_fault)); // R3
    AST_INTR_ABOVE_TASK: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> (pend_valid && pend_vector[7:4] > cra_rd_data[3:0])); // R6
    AST_INTR_ABOVE_ISV: assert property (@(posedge clk) disable iff (!rst_n)
        (intr && isv_valid) |-> (pend_vector[7:4] > isv_vector[7:4])); // R6
    AST_ACK_FOLLOWS_INTA: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> ack_valid); // R8
    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !inta |=> (!ack_valid && !ack_spurious)); // R8
    AST_SPURIOUS_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !intr) |=> ack_spurious); // R9
endmodule

bind task_prio_gate task_prio_gate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tpr_wr_en(tpr_wr_en), .cra_wr_en(cra_wr_en),
    .cra_wr_data(cra_wr_data), .cra_rd_data(cra_rd_data),
    .pend_valid(pend_valid), .pend_vector(pend_vector),
    .isv_valid(isv_valid), .isv_vector(isv_vector), .inta(inta),
    .intr(intr), .ack_valid(ack_valid), .ack_vector_unused_free(1'b0),
    .ack_spurious(ack_spurious), .tpr_value(tpr_value), .cra_fault(cra_fault)
);

// File: tb/task_prio_gate_bench.sv
// Bench: a scoreboard for the acknowledge path plus direct port checks.
module task_prio_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tpr_wr_en = 0, cra_wr_en = 0, spv_wr_en = 0;
    logic [7:0]  tpr_wr_data = 0, spv_wr_data = 0;
    logic [63:0] cra_wr_data = 0, cra_rd_data;
    logic        pend_valid = 0, isv_valid = 0, inta = 0;
    logic [7:0]  pend_vector = 0, isv_vector = 0;
    logic        intr, ack_valid, ack_spurious, cra_fault;
    logic [7:0]  ack_vector, tpr_value, spv_value;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] m_tpr = 8'h00, m_spv = 8'hFF;
    logic [8:0] exp_q[$];

    always #10 clk = ~clk;

    task_prio_gate u_task_prio_gate (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic model_elig();
        return pend_valid && (pend_vector[7:4] > m_tpr[7:4]) &&
               (!isv_valid || pend_vector[7:4] > isv_vector[7:4]);
    endfunction

    task automatic set_pend(input logic pv, input logic [7:0] p, input logic iv, input logic [7:0] i);
        @(negedge clk);
        pend_valid = pv; pend_vector = p; isv_valid = iv; isv_vector = i;
        #1;
    endtask

    task automatic wr_tpr(input logic [7:0] d);
        @(negedge clk); tpr_wr_en = 1; tpr_wr_data = d;
        @(negedge clk); tpr_wr_en = 0; m_tpr = d;
    endtask

    task automatic wr_cra(input logic [63:0] d);
        @(negedge clk); cra_wr_en = 1; cra_wr_data = d;
        @(negedge clk); cra_wr_en = 0;
        if (d[63:4] == 0) m_tpr = {d[3:0], 4'h0};
    endtask

    // Driver: compute the expected acknowledge, queue it, pulse inta.
    task automatic do_ack();
        @(negedge clk);
        if (model_elig()) exp_q.push_back({1'b0, pend_vector});
        else              exp_q.push_back({1'b1, m_spv});
        inta = 1;
        @(negedge clk); inta = 0;
        @(negedge clk);
    endtask

    // Monitor: pop and compare every acknowledge result (R8, R9).
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            if (exp_q.size() == 0) chk("R8 unexpected ack", 1, 0);
            else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(e[8] ? "R9 spurious ack" : "R8 real ack",
                    {ack_spurious, ack_vector}, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 tpr", tpr_value, 8'h00);
        chk("R1 spv", spv_value, 8'hFF);
        chk("R1 intr", intr, 0);
        chk("R1 ack_valid", ack_valid, 0);
        chk("R1 fault", cra_fault, 0);
        chk("R4 read after reset", cra_rd_data, 0);

        set_pend(1, 8'h35, 0, 8'h00);
        chk("R7 class0 passes", intr, 1);
        do_ack();

        wr_tpr(8'h5A);
        chk("R2 full write", tpr_value, 8'h5A);
        chk("R4 alias read", cra_rd_data, 64'h5);
        set_pend(1, 8'h35, 0, 8'h00); chk("R6 lower blocked", intr, 0);
        set_pend(1, 8'h55, 0, 8'h00); chk("R6 equal blocked", intr, 0);
        set_pend(1, 8'h65, 0, 8'h00); chk("R6 higher passes", intr, 1);
        set_pend(1, 8'h65, 1, 8'h70); chk("R6 isv blocks", intr, 0);
        set_pend(1, 8'h75, 1, 8'h70); chk("R6 isv equal blocks", intr, 0);
        set_pend(1, 8'h80, 1, 8'h70); chk("R6 above isv", intr, 1);
        set_pend(0, 8'h80, 0, 8'h00); chk("R6 no pending", intr, 0);

        wr_cra(64'h9);
        chk("R3 alias write", tpr_value, 8'h90);
        chk("R4 alias read", cra_rd_data, 64'h9);

        @(negedge clk); cra_wr_en = 1; cra_wr_data = 64'h13;
        @(negedge clk); cra_wr_en = 0;
        chk("R5 fault raised", cra_fault, 1);
        chk("R5 tpr held", tpr_value, 8'h90);
        @(negedge clk);
        chk("R5 fault one cycle", cra_fault, 0);
        wr_cra(64'h8000_0000_0000_0001);
        chk("R5 top bit held", tpr_value, 8'h90);

        wr_cra(64'hF);
        set_pend(1, 8'hFF, 0, 8'h00); chk("R7 class15 blocks", intr, 0);
        wr_cra(64'h0);
        set_pend(1, 8'h10, 0, 8'h00); chk("R7 class0 passes 1", intr, 1);

        @(negedge clk); spv_wr_en = 1; spv_wr_data = 8'h27;
        @(negedge clk); spv_wr_en = 0; m_spv = 8'h27;
        chk("R10 spv write", spv_value, 8'h27);

        set_pend(1, 8'hA4, 0, 8'h00); chk("R9 raised first", intr, 1);
        wr_cra(64'hA);
        chk("R9 now masked", intr, 0);
        do_ack();
        set_pend(1, 8'hB4, 0, 8'h00);
        do_ack();

        @(negedge clk); tpr_wr_en = 1; tpr_wr_data = 8'h33;
        cra_wr_en = 1; cra_wr_data = 64'hC;
        @(negedge clk); tpr_wr_en = 0; cra_wr_en = 0; m_tpr = 8'h33;
        chk("R2 full write wins", tpr_value, 8'h33);

        repeat (3) @(negedge clk);
        chk("R8 queue drained", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule